// File: doc/BRIEF.md
# Memory Dependence Wait and Wake Unit

This block sits beside the issue queue of an out-of-order core and decides when each load, store or barrier may be handed over for issue. An operation enters with a sequence number, a thread number, a kind and a predicted producer sequence number. The block picks the producer that the operation must wait for. An active barrier takes precedence over the prediction. The block then records two flags for each live operation: one for register readiness and one for dependence readiness. It hands an operation over only when both flags are set. Completing a store or a barrier wakes every operation that waits on it.

Squashes remove the younger operations of one thread. Operations that issue and then have to retry are parked in a replay set, which a single replay command releases all at once. Handed-over operations leave through a valid/ready port that carries the sequence number and the thread. When several operations become releasable in the same cycle, they leave one per cycle, oldest sequence number first. The table has a fixed number of slots. A full flag tells the front end to hold further inserts.

Commands arrive one per cycle on a single command port. Their effect is visible on the outputs after the next rising clock edge. Sequence number zero is reserved to mean "no producer" and is never given to a live operation.

Top module: `memdep_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, no release is offered, `full` is low and both conflict counters read zero.
- R2: An insert (op code 1) of a load (kind 0) takes the active load barrier as its producer, and a store (kind 1) takes the active store barrier. Otherwise the producer is `cmd_pred`. A barrier insert (op 3) of kind 2 arms both barriers and of kind 3 arms only the store barrier. Completing the barrier, or squashing it, disarms it.
- R3: If the chosen producer is zero or is not a live entry, the new operation is dependence-ready at once. It is released on the next cycle when `cmd_regs_rdy` was set with the insert.
- R4: If the producer is live, the operation waits on it. A waiting load increments `ld_conflicts` and a waiting store increments `st_conflicts`, each by one.
- R5: A register-ready command (op 4) releases the named entry if it is already dependence-ready. Otherwise the entry keeps waiting.
- R6: Completing (op 8) a store or a barrier wakes all of its waiters. Waiters with ready registers are released, and the others become dependence-ready. Completing a load wakes nothing.
- R7: Entries inserted as non-speculative (op 2) or as barriers (op 3) are never released by register readiness. They are released only by a non-speculative-ready command (op 5).
- R8: A reschedule command (op 6) parks the named entry. A replay command (op 7) releases every parked entry at once and leaves none parked.
- R9: A squash (op 9) with thread T and sequence S removes every entry of thread T that is younger than S. This includes entries that are parked, pending or waiting. Entries of other threads are left alone.
- R10: Completing an entry removes it. Later commands naming that sequence number have no effect.
- R11: `full` is high exactly when all NUM_ENT slots are live. An insert issued while full is dropped.
- R12: Releases leave one per cycle, oldest sequence number first. An offered release holds its value while `rel_ready` is low and no command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (1 insert, 2 non-speculative insert, 3 barrier insert, 4 registers ready, 5 non-speculative ready, 6 reschedule, 7 replay, 8 complete, 9 squash) |
| cmd_kind | input | 2 | Operation kind: 0 load, 1 store, 2 full barrier, 3 store-only barrier |
| cmd_seq | input | SEQ_W | Sequence number named by the command |
| cmd_tid | input | TID_W | Thread number |
| cmd_pred | input | SEQ_W | Predicted producer sequence number, zero for none |
| cmd_regs_rdy | input | 1 | Source registers already ready at insert |
| full | output | 1 | All slots live; inserts are dropped |
| rel_valid | output | 1 | A released operation is offered |
| rel_ready | input | 1 | Issue side accepts the offered operation |
| rel_seq | output | SEQ_W | Sequence number of the offered operation |
| rel_tid | output | TID_W | Thread of the offered operation |
| ld_conflicts | output | CNT_W | Count of loads that had to wait on a producer |
| st_conflicts | output | CNT_W | Count of stores that had to wait on a producer |

## Verification
The hardest state to reach from the ports is a wake that releases several waiters in the same cycle while the release port is stalled. The order of the releases and their stability then decide the result. The stimulus builds this state with a full barrier that holds back both a load and a store, completes the barrier, and holds `rel_ready` low for a cycle before draining. Squashes are also aimed at parked entries and at a barrier with a live waiter, so that removal, disarming and dropped replays can be seen on the release port.

// File: rtl/memdep_pkg.sv
package memdep_pkg;

  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_INS     = 4'd1,
    OP_INS_NS  = 4'd2,
    OP_INS_BAR = 4'd3,
    OP_REGS    = 4'd4,
    OP_NS_RDY  = 4'd5,
    OP_RESCHED = 4'd6,
    OP_REPLAY  = 4'd7,
    OP_DONE    = 4'd8,
    OP_SQUASH  = 4'd9
  } memdep_op_e;

  typedef enum logic [1:0] {
    K_LOAD   = 2'd0,
    K_STORE  = 2'd1,
    K_MEMBAR = 2'd2,
    K_WRBAR  = 2'd3
  } memdep_kind_e;

endpackage

// File: rtl/memdep_free_pick.sv
// Lowest-index free slot finder.
module memdep_free_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] busy,
  output logic [N-1:0] grant,
  output logic         any_free
);

  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign any_free = ~&busy;

endmodule

// File: rtl/memdep_seq_cam.sv
// Sequence-number lookup across live slots; key zero never matches.
module memdep_seq_cam #(
  parameter int N     = 16,
  parameter int SEQ_W = 16
) (
  input  logic [N-1:0]       live,
  input  logic [N*SEQ_W-1:0] seq_flat,
  input  logic [SEQ_W-1:0]   key,
  output logic [N-1:0]       hit_oh,
  output logic               hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_oh[g] = live[g] && (key != '0) &&
                       (seq_flat[g*SEQ_W +: SEQ_W] == key);
  end

  assign hit = |hit_oh;

endmodule

// File: rtl/memdep_age_pick.sv
// Picks the requesting slot holding the smallest sequence number.
module memdep_age_pick #(
  parameter int N     = 16,
  parameter int SEQ_W = 16
) (
  input  logic [N-1:0]       req,
  input  logic [N*SEQ_W-1:0] seq_flat,
  output logic [N-1:0]       gnt,
  output logic [SEQ_W-1:0]   gnt_seq,
  output logic               any_req
);

  always_comb begin
    logic found;
    found   = 1'b0;
    gnt     = '0;
    gnt_seq = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found || (seq_flat[i*SEQ_W +: SEQ_W] < gnt_seq))) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_seq = seq_flat[i*SEQ_W +: SEQ_W];
        found   = 1'b1;
      end
    end
  end

  assign any_req = |req;

endmodule

// File: rtl/memdep_tracker.sv
module memdep_tracker
  import memdep_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int SEQ_W   = 16,
  parameter int TID_W   = 1,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_op,
  input  logic [1:0]       cmd_kind,
  input  logic [SEQ_W-1:0] cmd_seq,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic [SEQ_W-1:0] cmd_pred,
  input  logic             cmd_regs_rdy,
  output logic             full,
  output logic             rel_valid,
  input  logic             rel_ready,
  output logic [SEQ_W-1:0] rel_seq,
  output logic [TID_W-1:0] rel_tid,
  output logic [CNT_W-1:0] ld_conflicts,
  output logic [CNT_W-1:0] st_conflicts
);

  localparam int FLAT_W = NUM_ENT * SEQ_W;

  memdep_op_e   op;
  memdep_kind_e kind;
  assign op   = memdep_op_e'(cmd_op);
  assign kind = memdep_kind_e'(cmd_kind);

  // Slot state
  logic [NUM_ENT-1:0] valid_q, regs_q, dep_q, held_q, pend_q;
  logic [NUM_ENT-1:0] valid_n, regs_n, dep_n, held_n, pend_n;
  logic [NUM_ENT-1:0] wait_q [NUM_ENT];
  logic [NUM_ENT-1:0] wait_n [NUM_ENT];
  logic [SEQ_W-1:0]   seq_q  [NUM_ENT];
  logic [TID_W-1:0]   tid_q  [NUM_ENT];
  memdep_kind_e       kind_q [NUM_ENT];

  // Barrier state
  logic             ldb_act_q, stb_act_q, ldb_act_n, stb_act_n;
  logic [SEQ_W-1:0] ldb_seq_q, stb_seq_q, ldb_seq_n, stb_seq_n;

  logic [CNT_W-1:0] ld_cnt_q, st_cnt_q, ld_cnt_n, st_cnt_n;

  logic [NUM_ENT-1:0] wr_en;
  logic [NUM_ENT-1:0] kill;

  // Flattened sequence numbers for the lookup helpers
  logic [FLAT_W-1:0] seq_flat;
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_flat
    assign seq_flat[g*SEQ_W +: SEQ_W] = seq_q[g];
  end

  // Slots younger than a squash point in the squashed thread
  logic [NUM_ENT-1:0] younger;
  for (genvar g = 0; g < NUM_ENT; g++) begin : g_young
    assign younger[g] = valid_q[g] && (tid_q[g] == cmd_tid) && (seq_q[g] > cmd_seq);
  end

  // Free slot
  logic [NUM_ENT-1:0] free_oh;
  logic               any_free;
  memdep_free_pick #(.N(NUM_ENT)) u_free (
    .busy     (valid_q),
    .grant    (free_oh),
    .any_free (any_free)
  );

  // Producer choice and lookup
  logic [SEQ_W-1:0] prod_seq;
  always_comb begin
    if (kind == K_LOAD && ldb_act_q)       prod_seq = ldb_seq_q;
    else if (kind == K_STORE && stb_act_q) prod_seq = stb_seq_q;
    else                                   prod_seq = cmd_pred;
  end

  logic [NUM_ENT-1:0] prod_oh;
  logic               prod_hit;
  memdep_seq_cam #(.N(NUM_ENT), .SEQ_W(SEQ_W)) u_prod_cam (
    .live     (valid_q),
    .seq_flat (seq_flat),
    .key      (prod_seq),
    .hit_oh   (prod_oh),
    .hit      (prod_hit)
  );

  // Target lookup for commands naming an existing entry
  logic [NUM_ENT-1:0] tgt_oh;
  logic               tgt_hit;
  memdep_seq_cam #(.N(NUM_ENT), .SEQ_W(SEQ_W)) u_tgt_cam (
    .live     (valid_q),
    .seq_flat (seq_flat),
    .key      (cmd_seq),
    .hit_oh   (tgt_oh),
    .hit      (tgt_hit)
  );

  // Release selection
  logic [NUM_ENT-1:0] pick_oh;
  logic               pick_any;
  memdep_age_pick #(.N(NUM_ENT), .SEQ_W(SEQ_W)) u_age (
    .req      (pend_q),
    .seq_flat (seq_flat),
    .gnt      (pick_oh),
    .gnt_seq  (rel_seq),
    .any_req  (pick_any)
  );

  assign rel_valid = pick_any;

  always_comb begin
    rel_tid = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (pick_oh[i]) rel_tid = tid_q[i];
    end
  end

  assign full         = ~any_free;
  assign ld_conflicts = ld_cnt_q;
  assign st_conflicts = st_cnt_q;

  // Next state
  always_comb begin
    logic [NUM_ENT-1:0] wake;
    logic               is_ins;
    valid_n   = valid_q;
    regs_n    = regs_q;
    dep_n     = dep_q;
    held_n    = held_q;
    pend_n    = pend_q;
    wait_n    = wait_q;
    ldb_act_n = ldb_act_q;
    ldb_seq_n = ldb_seq_q;
    stb_act_n = stb_act_q;
    stb_seq_n = stb_seq_q;
    ld_cnt_n  = ld_cnt_q;
    st_cnt_n  = st_cnt_q;
    wr_en     = '0;
    kill      = '0;
    wake      = '0;
    is_ins    = cmd_valid && (op == OP_INS || op == OP_INS_NS || op == OP_INS_BAR);

    // Accepted release leaves the pending set first
    if (rel_valid && rel_ready) pend_n = pend_n & ~pick_oh;

    if (is_ins && any_free) begin
      wr_en   = free_oh;
      valid_n = valid_n | free_oh;
      held_n  = held_n & ~free_oh;
      pend_n  = pend_n & ~free_oh;
      if (cmd_regs_rdy) regs_n = regs_n | free_oh;
      else              regs_n = regs_n & ~free_oh;
      for (int i = 0; i < NUM_ENT; i++) begin
        if (free_oh[i]) wait_n[i] = '0;
      end
      if (op == OP_INS) begin
        if (prod_hit) begin
          dep_n = dep_n & ~free_oh;
          for (int p = 0; p < NUM_ENT; p++) begin
            if (prod_oh[p]) wait_n[p] = wait_n[p] | free_oh;
          end
          if (kind == K_LOAD)       ld_cnt_n = ld_cnt_q + CNT_W'(1);
          else if (kind == K_STORE) st_cnt_n = st_cnt_q + CNT_W'(1);
        end else begin
          dep_n = dep_n | free_oh;
          if (cmd_regs_rdy) pend_n = pend_n | free_oh;
        end
      end else begin
        dep_n = dep_n & ~free_oh;
      end
      if (op == OP_INS_BAR) begin
        if (kind == K_MEMBAR) begin
          ldb_act_n = 1'b1;
          ldb_seq_n = cmd_seq;
          stb_act_n = 1'b1;
          stb_seq_n = cmd_seq;
        end else if (kind == K_WRBAR) begin
          stb_act_n = 1'b1;
          stb_seq_n = cmd_seq;
        end
      end
    end else if (cmd_valid) begin
      unique case (op)
        OP_REGS: begin
          regs_n = regs_n | tgt_oh;
          pend_n = pend_n | (tgt_oh & dep_q);
        end
        OP_NS_RDY:  pend_n = pend_n | tgt_oh;
        OP_RESCHED: held_n = held_n | tgt_oh;
        OP_REPLAY: begin
          pend_n = pend_n | held_q;
          held_n = '0;
        end
        OP_DONE: begin
          for (int i = 0; i < NUM_ENT; i++) begin
            if (tgt_oh[i] && kind_q[i] != K_LOAD) wake = wake | (wait_q[i] & valid_q);
          end
          dep_n  = dep_n | wake;
          pend_n = pend_n | (wake & regs_q);
          kill   = tgt_oh;
          if (tgt_hit && ldb_act_q && ldb_seq_q == cmd_seq) ldb_act_n = 1'b0;
          if (tgt_hit && stb_act_q && stb_seq_q == cmd_seq) stb_act_n = 1'b0;
        end
        OP_SQUASH: begin
          kill = younger;
          for (int i = 0; i < NUM_ENT; i++) begin
            if (younger[i] && ldb_act_q && seq_q[i] == ldb_seq_q) ldb_act_n = 1'b0;
            if (younger[i] && stb_act_q && seq_q[i] == stb_seq_q) stb_act_n = 1'b0;
          end
        end
        default: ;
      endcase
    end

    // Removal: slot state and every waiter column
    valid_n = valid_n & ~kill;
    pend_n  = pend_n & ~kill;
    held_n  = held_n & ~kill;
    for (int r = 0; r < NUM_ENT; r++) begin
      if (kill[r]) wait_n[r] = '0;
      else         wait_n[r] = wait_n[r] & ~kill;
    end
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= '0;
      regs_q    <= '0;
      dep_q     <= '0;
      held_q    <= '0;
      pend_q    <= '0;
      ldb_act_q <= 1'b0;
      stb_act_q <= 1'b0;
      ldb_seq_q <= '0;
      stb_seq_q <= '0;
      ld_cnt_q  <= '0;
      st_cnt_q  <= '0;
      for (int i = 0; i < NUM_ENT; i++) wait_q[i] <= '0;
    end else begin
      valid_q   <= valid_n;
      regs_q    <= regs_n;
      dep_q     <= dep_n;
      held_q    <= held_n;
      pend_q    <= pend_n;
      ldb_act_q <= ldb_act_n;
      stb_act_q <= stb_act_n;
      ldb_seq_q <= ldb_seq_n;
      stb_seq_q <= stb_seq_n;
      ld_cnt_q  <= ld_cnt_n;
      st_cnt_q  <= st_cnt_n;
      for (int i = 0; i < NUM_ENT; i++) wait_q[i] <= wait_n[i];
    end
  end

  // Payload registers, written on allocation only
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (wr_en[i]) begin
        seq_q[i]  <= cmd_seq;
        tid_q[i]  <= cmd_tid;
        kind_q[i] <= kind;
      end
    end
  end

endmodule

// File: rtl/memdep_tracker_sva.sv
module memdep_tracker_sva #(
  parameter int NUM_ENT = 16,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic [3:0]         cmd_op,
  input logic               full,
  input logic               rel_valid,
  input logic               rel_ready,
  input logic [SEQ_W-1:0]   rel_seq,
  input logic [CNT_W-1:0]   ld_conflicts,
  input logic [CNT_W-1:0]   st_conflicts,
  input logic [NUM_ENT-1:0] valid_q,
  input logic [NUM_ENT-1:0] pend_q,
  input logic [NUM_ENT-1:0] held_q
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!rel_valid && !full && ld_conflicts == '0 && st_conflicts == '0)
        else $error("R1 outputs not quiet in reset");
    end
  end

  p_full_drops_insert_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && cmd_valid && (cmd_op == 4'd1 || cmd_op == 4'd2 || cmd_op == 4'd3))
    |=> $stable(valid_q));

  p_pending_is_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & ~valid_q) == '0);

  p_hold_when_stalled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && !rel_ready && !cmd_valid) |=> (rel_valid && $stable(rel_seq)));

  p_ld_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_conflicts != $past(ld_conflicts)) |->
    ($past(cmd_valid) && $past(cmd_op) == 4'd1 && ld_conflicts == $past(ld_conflicts) + CNT_W'(1)));

  p_st_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_conflicts != $past(st_conflicts)) |->
    ($past(cmd_valid) && $past(cmd_op) == 4'd1 && st_conflicts == $past(st_conflicts) + CNT_W'(1)));

  p_replay_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 4'd7) |=> (held_q == '0));

endmodule

bind memdep_tracker memdep_tracker_sva #(
  .NUM_ENT (NUM_ENT),
  .SEQ_W   (SEQ_W),
  .CNT_W   (CNT_W)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_op       (cmd_op),
  .full         (full),
  .rel_valid    (rel_valid),
  .rel_ready    (rel_ready),
  .rel_seq      (rel_seq),
  .ld_conflicts (ld_conflicts),
  .st_conflicts (st_conflicts),
  .valid_q      (valid_q),
  .pend_q       (pend_q),
  .held_q       (held_q)
);

// File: tb/memdep_tracker_tb.sv
module memdep_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NENT       = 16;
  localparam int SW         = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [3:0]    cmd_op;
  logic [1:0]    cmd_kind;
  logic [SW-1:0] cmd_seq;
  logic [0:0]    cmd_tid;
  logic [SW-1:0] cmd_pred;
  logic          cmd_regs_rdy;
  logic          full;
  logic          rel_valid;
  logic          rel_ready;
  logic [SW-1:0] rel_seq;
  logic [0:0]    rel_tid;
  logic [15:0]   ld_conflicts;
  logic [15:0]   st_conflicts;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  memdep_tracker u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_kind     (cmd_kind),
    .cmd_seq      (cmd_seq),
    .cmd_tid      (cmd_tid),
    .cmd_pred     (cmd_pred),
    .cmd_regs_rdy (cmd_regs_rdy),
    .full         (full),
    .rel_valid    (rel_valid),
    .rel_ready    (rel_ready),
    .rel_seq      (rel_seq),
    .rel_tid      (rel_tid),
    .ld_conflicts (ld_conflicts),
    .st_conflicts (st_conflicts)
  );

  // Behavioural reference, keyed by sequence number
  int m_tid  [int];
  int m_kind [int];
  int m_prod [int];
  bit m_regs [int];
  bit m_dep  [int];
  bit m_held [int];
  bit m_pend [int];
  int m_tidq [int];
  bit ldb_act = 0, stb_act = 0;
  int ldb_seq = 0, stb_seq = 0;
  int m_ld = 0, m_st = 0;

  function automatic bit m_oldest(output int s);
    s = 0;
    foreach (m_pend[k]) begin
      if (m_pend[k]) begin
        s = k;
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic void m_remove(int s);
    if (ldb_act && ldb_seq == s) ldb_act = 0;
    if (stb_act && stb_seq == s) stb_act = 0;
    m_tid.delete(s); m_kind.delete(s); m_prod.delete(s); m_regs.delete(s);
    m_dep.delete(s); m_held.delete(s); m_pend.delete(s);
  endfunction

  function automatic void m_apply(int op, int kind, int seq, int tid, int pred, bit regs);
    int p;
    bit hit;
    int gone[$];
    case (op)
      1, 2, 3: begin
        if (m_tid.num() < NENT) begin
          hit = 0;
          if (op == 1) begin
            if (kind == 0 && ldb_act)      p = ldb_seq;
            else if (kind == 1 && stb_act) p = stb_seq;
            else                           p = pred;
            hit = (p != 0) && m_tid.exists(p);
          end
          m_tid[seq] = tid; m_kind[seq] = kind; m_regs[seq] = regs;
          m_held[seq] = 0; m_pend[seq] = 0; m_prod[seq] = 0;
          m_dep[seq] = (op == 1) && !hit;
          if (hit) begin
            m_prod[seq] = p;
            if (kind == 0) m_ld++;
            else if (kind == 1) m_st++;
          end else if (op == 1 && regs) m_pend[seq] = 1;
          if (op == 3 && kind == 2) begin ldb_act = 1; ldb_seq = seq; stb_act = 1; stb_seq = seq; end
          if (op == 3 && kind == 3) begin stb_act = 1; stb_seq = seq; end
        end
      end
      4: if (m_tid.exists(seq)) begin
           m_regs[seq] = 1;
           if (m_dep[seq]) m_pend[seq] = 1;
         end
      5: if (m_tid.exists(seq)) m_pend[seq] = 1;
      6: if (m_tid.exists(seq)) m_held[seq] = 1;
      7: foreach (m_held[k]) if (m_held[k]) begin m_pend[k] = 1; m_held[k] = 0; end
      8: if (m_tid.exists(seq)) begin
           if (m_kind[seq] != 0) begin
             foreach (m_prod[k]) begin
               if (m_prod[k] == seq) begin
                 m_prod[k] = 0; m_dep[k] = 1;
                 if (m_regs[k]) m_pend[k] = 1;
               end
             end
           end
           m_remove(seq);
         end
      9: begin
           foreach (m_tid[k]) if (m_tid[k] == tid && k > seq) gone.push_back(k);
           foreach (gone[i]) m_remove(gone[i]);
         end
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int s;
    bit v;
    v = m_oldest(s);
    chk(tag, "rel_valid", int'(rel_valid), int'(v));
    if (v) chk(tag, "rel_seq", int'(rel_seq), s);
    if (v) chk(tag, "rel_tid", int'(rel_tid), m_tid[s]);
    chk("R11", "full", int'(full), int'(m_tid.num() == NENT));
    chk("R4", "ld_conflicts", int'(ld_conflicts), m_ld);
    chk("R4", "st_conflicts", int'(st_conflicts), m_st);
  endtask

  task automatic step(input int op, input int kind, input int seq, input int tid,
                      input int pred, input bit regs, input bit rdy, input string tag);
    int s;
    cmd_valid    = (op != 0);
    cmd_op       = 4'(op);
    cmd_kind     = 2'(kind);
    cmd_seq      = SW'(seq);
    cmd_tid      = 1'(tid);
    cmd_pred     = SW'(pred);
    cmd_regs_rdy = regs;
    rel_ready    = rdy;
    if (rdy && m_oldest(s)) m_pend[s] = 0;
    m_apply(op, kind, seq, tid, pred, regs);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input bit rdy, input string tag);
    step(0, 0, 0, 0, 0, 1'b0, rdy, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_kind = 0; cmd_seq = 0;
    cmd_tid = 0; cmd_pred = 0; cmd_regs_rdy = 0; rel_ready = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // Free producer and waiting on a live store
    step(1, 0, 10, 0, 0, 1, 1, "R3");
    idle(1, "R12");
    step(1, 1, 20, 0, 0, 1, 1, "R3");
    idle(1, "R12");
    step(1, 0, 21, 0, 20, 1, 1, "R4");
    step(1, 1, 22, 0, 20, 0, 1, "R4");
    step(8, 1, 20, 0, 0, 0, 1, "R6");
    idle(1, "R6");
    step(4, 1, 22, 0, 0, 0, 1, "R5");
    idle(1, "R5");
    step(1, 0, 23, 0, 99, 0, 1, "R3");
    step(4, 0, 23, 0, 0, 0, 1, "R5");
    idle(1, "R5");

    // Full barrier holds a load and a store, wake releases both oldest first
    step(3, 2, 30, 0, 0, 1, 1, "R7");
    step(1, 0, 31, 0, 0, 1, 1, "R2");
    step(1, 1, 32, 0, 0, 1, 1, "R2");
    step(4, 2, 30, 0, 0, 0, 1, "R7");
    step(5, 2, 30, 0, 0, 0, 1, "R7");
    idle(0, "R12");
    idle(1, "R12");
    step(8, 2, 30, 0, 0, 0, 0, "R6");
    idle(0, "R12");
    idle(1, "R12");
    idle(1, "R12");
    step(1, 0, 33, 0, 0, 1, 1, "R2");
    idle(1, "R2");

    // Store-only barrier, then squash that disarms it
    step(3, 3, 40, 0, 0, 1, 1, "R2");
    step(1, 0, 41, 0, 0, 1, 1, "R2");
    step(1, 1, 42, 0, 0, 1, 0, "R2");
    step(9, 0, 39, 0, 0, 0, 1, "R9");
    step(1, 1, 43, 0, 0, 1, 1, "R9");
    idle(1, "R9");

    // Non-speculative entry
    step(2, 0, 50, 0, 0, 1, 1, "R7");
    step(4, 0, 50, 0, 0, 0, 1, "R7");
    step(5, 0, 50, 0, 0, 0, 1, "R7");
    idle(1, "R7");

    // Replay set
    step(6, 0, 21, 0, 0, 0, 1, "R8");
    step(6, 0, 10, 0, 0, 0, 1, "R8");
    step(7, 0, 0, 0, 0, 0, 1, "R8");
    idle(1, "R8");
    idle(1, "R8");
    step(6, 0, 50, 0, 0, 0, 1, "R8");
    step(9, 0, 49, 0, 0, 0, 1, "R9");
    step(7, 0, 0, 0, 0, 0, 1, "R9");

    // Load completion wakes nothing; removed entry ignores commands
    step(1, 0, 60, 0, 0, 1, 1, "R3");
    step(1, 0, 61, 0, 60, 1, 1, "R4");
    step(8, 0, 60, 0, 0, 0, 1, "R6");
    step(8, 0, 61, 0, 0, 0, 1, "R10");
    step(4, 0, 61, 0, 0, 0, 1, "R10");
    step(5, 0, 61, 0, 0, 0, 1, "R10");

    // Thread isolation of squash
    step(1, 0, 70, 1, 0, 0, 1, "R9");
    step(1, 0, 71, 0, 0, 0, 1, "R9");
    step(9, 0, 65, 0, 0, 0, 1, "R9");
    step(4, 0, 70, 1, 0, 0, 1, "R9");
    idle(1, "R9");
    step(4, 0, 71, 0, 0, 0, 1, "R9");

    // Fill the table
    step(9, 0, 0, 0, 0, 0, 1, "R9");
    step(9, 0, 0, 1, 0, 0, 1, "R9");
    for (int i = 0; i < NENT; i++) step(1, 0, 100 + i, 1, 0, 0, 1, "R11");
    step(1, 0, 116, 1, 0, 1, 1, "R11");
    idle(1, "R11");
    step(8, 0, 100, 1, 0, 0, 1, "R11");
    step(1, 0, 116, 1, 0, 1, 1, "R11");
    idle(1, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule